// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects interrupt requests from up to 31 peripheral sources and merges them into a single cascaded interrupt line towards the host processor. Each request is held in a pending bit until software acknowledges it. A per-source enable mask decides which held requests may raise the cascaded line. A global enable in the configuration register gates that line as a whole. A three-bit level field travels alongside the line so the host knows at which level to take it.

When the line is up, software asks which source to serve. It writes the acknowledge bit of the vector register, which freezes the number of the winning source. It then reads that number back from bits 15:11 of the same register. Sources are ranked by number, and a higher number wins. A configurable source can be promoted above all others. The four highest ranks form a group of slots, and software can assign four fast channels to those slots in any order. Vector 0 is not a peripheral. It flags the race in which software disables the source that is currently being presented. That event sets pending bit 0. The race condition then raises the line by itself, and software clears it like any other source.

Top module: `vpic_top`

## Requirements
- R1: After synchronous reset the pending and mask registers read 0, the vector register reads 0, the configuration register reads 0x000000E4 (identity slot map), and the cascaded output is low.
- R2: A high level on request line i (1..31) at a clock edge sets pending bit i at that edge. Pending bit 0 is never set by a request line.
- R3: Writing the pending register (address 1) clears every bit written as 1 and leaves bits written as 0 unchanged. A request arriving in the same cycle as its clear leaves the bit set.
- R4: A source takes part in the output and the priority pick only while its mask bit (address 2, bit i) is 1.
- R5: The cascaded output is high exactly when the global enable (configuration bit 23) is 1 and either some source 1..31 is pending and unmasked or pending bit 0 is set.
- R6: Among pending, unmasked sources the picked vector is the one with the highest rank, and source n below 28 has rank n.
- R7: When the promote field (configuration bits 12:8) holds a nonzero source number and that source is pending and unmasked, it is picked ahead of every other source.
- R8: Ranks 28..31 are slots 0..3. Slot k is filled by fast channel m (source 28+m), where m is the 2-bit field at configuration bits 2k+1:2k. A fast channel named by no slot is never picked.
- R9: Writing the vector register (address 3) with bit 0 set captures the current pick. Reads of that register return the captured number in bits 15:11 with all other bits 0. A write with bit 0 clear changes nothing.
- R10: A capture made while no source 1..31 is pending and unmasked records vector 0.
- R11: A mask write that clears the mask bit of the currently picked source sets pending bit 0. That bit keeps the output high (R5) until software clears it by writing 1 to pending bit 0.
- R12: The level output always equals configuration bits 15:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 31 | Request lines of sources 1..31 (bit i is source i) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 config, 1 pending, 2 mask, 3 vector |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Cascaded interrupt to the host |
| irq_level_o | output | 3 | Request level taken from the configuration |

## Verification
The bench builds the block with its default sizes: 32 vector positions, of which the top four ranks form the fast-channel slot group. This places the slot remapping, the promotion of a low-numbered source and the fast-versus-ordinary rank boundary at 27/28 all within reach. With these sizes the bench can drive the race between masking and presentation that raises vector 0, as well as a fast channel left out of every slot. A behavioural model tracks the pending, mask, configuration and captured vector state and is compared against the line and level outputs on every clock.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_SRC   = 32;
    localparam int unsigned VEC_W     = $clog2(NUM_SRC);
    localparam int unsigned NUM_FAST  = 4;
    localparam int unsigned SLOT_W    = $clog2(NUM_FAST);
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned LVL_W     = 3;

    // field placement inside the configuration word
    localparam int unsigned MAP_LSB   = 0;
    localparam int unsigned HPS_LSB   = 8;
    localparam int unsigned LVL_LSB   = 13;
    localparam int unsigned EN_BIT    = 23;
    // captured vector placement inside the vector register
    localparam int unsigned VEC_LSB   = 11;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG  = 2'd0,
        REG_PEND = 2'd1,
        REG_MASK = 2'd2,
        REG_VEC  = 2'd3
    } reg_sel_e;

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [NUM_FAST-1:0][SLOT_W-1:0] slot_map_t;

    typedef struct packed {
        logic            en;
        logic [LVL_W-1:0] level;
        vec_t            hp_sel;
        slot_map_t       slot_map;
    } cfg_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
    } pick_t;

    localparam vec_t ERR_VEC = '0;

    function automatic slot_map_t ident_map();
        slot_map_t m;
        for (int k = 0; k < NUM_FAST; k++) begin
            m[k] = SLOT_W'(k);
        end
        return m;
    endfunction

    localparam cfg_t CFG_RESET = '{en: 1'b0, level: '0, hp_sel: '0, slot_map: ident_map()};

    function automatic cfg_t cfg_unpack(input logic [DATA_W-1:0] w);
        cfg_t c;
        c.en       = w[EN_BIT];
        c.level    = w[LVL_LSB +: LVL_W];
        c.hp_sel   = w[HPS_LSB +: VEC_W];
        c.slot_map = w[MAP_LSB +: NUM_FAST*SLOT_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_pack(input cfg_t c);
        logic [DATA_W-1:0] w;
        w                           = '0;
        w[EN_BIT]                   = c.en;
        w[LVL_LSB +: LVL_W]         = c.level;
        w[HPS_LSB +: VEC_W]         = c.hp_sel;
        w[MAP_LSB +: NUM_FAST*SLOT_W] = c.slot_map;
        return w;
    endfunction

endpackage

// File: rtl/vpic_pend.sv
module vpic_pend #(
    parameter int unsigned NUM_SRC = vpic_pkg::NUM_SRC
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;
        // a set in the same cycle as a clear wins
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                bit_q <= 1'b0;
            end else if (set_i[i]) begin
                bit_q <= 1'b1;
            end else if (clr_i[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign pend_o[i] = bit_q;
    end

endmodule

// File: rtl/vpic_prio.sv
module vpic_prio
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = vpic_pkg::NUM_SRC,
    parameter int unsigned NUM_FAST = vpic_pkg::NUM_FAST
) (
    input  logic [NUM_SRC-1:1] act_i,
    input  vec_t               hp_sel_i,
    input  slot_map_t          slot_map_i,
    output pick_t              pick_o
);

    localparam int unsigned FAST_LO = NUM_SRC - NUM_FAST;

    logic [NUM_SRC-1:0] act_full;
    logic [NUM_SRC-1:1] rank_act;
    vec_t               rank_src [NUM_SRC-1:1];

    assign act_full = {act_i, 1'b0};

    // map every rank to the source that occupies it
    for (genvar r = 1; r < NUM_SRC; r++) begin : g_rank
        if (r < FAST_LO) begin : g_plain
            assign rank_src[r] = vec_t'(r);
        end else begin : g_slot
            assign rank_src[r] = vec_t'(FAST_LO) + vec_t'(slot_map_i[r-FAST_LO]);
        end
        assign rank_act[r] = act_full[rank_src[r]];
    end

    always_comb begin
        pick_o = '{valid: 1'b0, vec: ERR_VEC};
        for (int r = 1; r < NUM_SRC; r++) begin
            if (rank_act[r]) begin
                pick_o = '{valid: 1'b1, vec: rank_src[r]};
            end
        end
        if (hp_sel_i != ERR_VEC && act_full[hp_sel_i]) begin
            pick_o = '{valid: 1'b1, vec: hp_sel_i};
        end
    end

endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_SRC = vpic_pkg::NUM_SRC
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] pend_i,
    input  pick_t              pick_i,
    output cfg_t               cfg_o,
    output logic [NUM_SRC-1:0] mask_o,
    output vec_t               vec_lat_o,
    output logic [NUM_SRC-1:0] pend_clr_o,
    output logic               err_set_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e sel;
    logic     wr_cfg, wr_pend, wr_mask, wr_vec;

    cfg_t               cfg_q;
    logic [NUM_SRC-1:0] mask_q;
    vec_t               vec_q;

    assign sel     = reg_sel_e'(addr_i);
    assign wr_cfg  = wr_i && (sel == REG_CFG);
    assign wr_pend = wr_i && (sel == REG_PEND);
    assign wr_mask = wr_i && (sel == REG_MASK);
    assign wr_vec  = wr_i && (sel == REG_VEC);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q  <= CFG_RESET;
            mask_q <= '0;
            vec_q  <= ERR_VEC;
        end else begin
            if (wr_cfg) begin
                cfg_q <= cfg_unpack(wdata_i);
            end
            if (wr_mask) begin
                mask_q <= wdata_i[NUM_SRC-1:0];
            end
            if (wr_vec && wdata_i[0]) begin
                vec_q <= pick_i.valid ? pick_i.vec : ERR_VEC;
            end
        end
    end

    assign pend_clr_o = wr_pend ? wdata_i[NUM_SRC-1:0] : '0;
    assign err_set_o  = wr_mask && pick_i.valid && !wdata_i[pick_i.vec];

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_CFG:  rdata_o = cfg_pack(cfg_q);
            REG_PEND: rdata_o[NUM_SRC-1:0] = pend_i;
            REG_MASK: rdata_o[NUM_SRC-1:0] = mask_q;
            REG_VEC:  rdata_o[VEC_LSB +: VEC_W] = vec_q;
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o     = cfg_q;
    assign mask_o    = mask_q;
    assign vec_lat_o = vec_q;

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_SRC  = vpic_pkg::NUM_SRC,
    parameter int unsigned NUM_FAST = vpic_pkg::NUM_FAST
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:1] irq_req_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o,
    output logic [LVL_W-1:0]   irq_level_o
);

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_clr;
    logic [NUM_SRC-1:0] pend_set;
    logic [NUM_SRC-1:1] src_act;
    logic               err_set;
    cfg_t               cfg;
    vec_t               vec_lat;
    pick_t              pick;

    // bit 0 of the pending array is the race flag, not a request line
    assign pend_set = {irq_req_i, err_set};
    assign src_act  = pend_q[NUM_SRC-1:1] & mask_q[NUM_SRC-1:1];

    vpic_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .pend_o (pend_q)
    );

    vpic_prio #(.NUM_SRC(NUM_SRC), .NUM_FAST(NUM_FAST)) u_prio (
        .act_i      (src_act),
        .hp_sel_i   (cfg.hp_sel),
        .slot_map_i (cfg.slot_map),
        .pick_o     (pick)
    );

    vpic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .pend_i     (pend_q),
        .pick_i     (pick),
        .cfg_o      (cfg),
        .mask_o     (mask_q),
        .vec_lat_o  (vec_lat),
        .pend_clr_o (pend_clr),
        .err_set_o  (err_set),
        .rdata_o    (reg_rdata_o)
    );

    assign irq_o       = cfg.en && ((|src_act) || pend_q[0]);
    assign irq_level_o = cfg.level;

endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
    import vpic_pkg::*;
#(
    parameter int unsigned NUM_SRC = vpic_pkg::NUM_SRC
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic [NUM_SRC-1:1] irq_req_i,
    input logic               reg_wr_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic               irq_o,
    input logic               en_i,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] mask_i,
    input vec_t               vec_lat_i,
    input logic               pick_valid_i,
    input vec_t               pick_vec_i
);

    AST_REQ_LATCHED: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((pend_i[NUM_SRC-1:1] & $past(irq_req_i)) == $past(irq_req_i))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_wr_i && reg_addr_i == REG_PEND)
        |=> ((pend_i[NUM_SRC-1:1] & $past(reg_wdata_i[NUM_SRC-1:1] & ~irq_req_i)) == '0)); // R3

    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> !irq_o); // R5

    AST_PICK_LIVE: assert property (@(posedge clk_i) disable iff (rst_i)
        pick_valid_i |-> (pend_i[pick_vec_i] && mask_i[pick_vec_i])); // R6

    AST_VEC_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !(reg_wr_i && reg_addr_i == REG_VEC && reg_wdata_i[0]) |=> $stable(vec_lat_i)); // R9

    AST_RACE_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (reg_wr_i && reg_addr_i == REG_MASK && pick_valid_i && !reg_wdata_i[pick_vec_i])
        |=> pend_i[0]); // R11

endmodule

bind vpic_top vpic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .irq_req_i    (irq_req_i),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .irq_o        (irq_o),
    .en_i         (cfg.en),
    .pend_i       (pend_q),
    .mask_i       (mask_q),
    .vec_lat_i    (vec_lat),
    .pick_valid_i (pick.valid),
    .pick_vec_i   (pick.vec)
);

// File: tb/vpic_top_tb_top.sv
module vpic_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:1] req;
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;
    logic [2:0]  lvl;

    always #5 clk = ~clk;

    vpic_top dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .irq_req_i   (req),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .irq_level_o (lvl)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [31:0] m_pend, m_mask, m_cfg;
    logic [4:0]  m_vlat;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int m_win(input logic [31:0] p, input logic [31:0] m, input logic [31:0] c);
        logic [31:0] a;
        int hp;
        a    = p & m;
        a[0] = 1'b0;
        hp   = int'(c[12:8]);
        if (hp != 0 && a[hp]) return hp;
        for (int r = 31; r >= 1; r--) begin
            int s;
            if (r < 28) s = r;
            else s = 28 + int'((c >> (2 * (r - 28))) & 32'd3);
            if (a[s]) return s;
        end
        return 0;
    endfunction

    function automatic logic m_irq();
        return m_cfg[23] && ((((m_pend & m_mask) & 32'hFFFF_FFFE) != 0) || m_pend[0]);
    endfunction

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_cfg;
            2'd1:    return m_pend;
            2'd2:    return m_mask;
            default: return {16'h0, m_vlat, 11'h0};
        endcase
    endfunction

    always @(posedge clk) begin : ref_model
        int w;
        logic [31:0] setv, clrv;
        if (rst) begin
            m_pend = '0; m_mask = '0; m_cfg = 32'h0000_00E4; m_vlat = '0;
        end else begin
            w    = m_win(m_pend, m_mask, m_cfg);
            setv = {req, 1'b0};
            clrv = '0;
            if (wr) begin
                case (addr)
                    2'd0: m_cfg = wdata & 32'h0080_FFFF;
                    2'd1: clrv = wdata;
                    2'd2: begin
                        if (w != 0 && !wdata[w]) setv[0] = 1'b1;
                        m_mask = wdata;
                    end
                    default: if (wdata[0]) m_vlat = 5'(w);
                endcase
            end
            m_pend = (m_pend & ~clrv) | setv;
        end
    end

    // compare line and level every cycle (R5, R12)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 cascaded line vs model", {31'h0, irq}, {31'h0, m_irq()});
            chk("R12 level vs model", {29'h0, lvl}, {29'h0, m_cfg[15:13]});
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, input string tag, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        chk({tag, " (model)"}, rdata, m_read(a));
    endtask

    task automatic pulse(input logic [31:0] bits);
        @(negedge clk);
        req = bits[31:1];
        @(negedge clk);
        req = '0;
    endtask

    task automatic capture();
        wr_reg(2'd3, 32'h1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        rst = 1'b1; req = '0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd0, "R1 config reset", 32'h0000_00E4);
        rd_reg(2'd1, "R1 pending reset", 32'h0);
        rd_reg(2'd2, "R1 mask reset", 32'h0);
        rd_reg(2'd3, "R1 vector reset", 32'h0);
        chk("R1 line low after reset", {31'h0, irq}, 32'h0);

        // enable, level 5
        wr_reg(2'd0, 32'h0080_A0E4);
        chk("R12 level field", {29'h0, lvl}, 32'd5);

        // R2 latch, masked source keeps line low (R4)
        pulse(32'h0000_0020);
        rd_reg(2'd1, "R2 request latched", 32'h0000_0020);
        chk("R4 masked source silent", {31'h0, irq}, 32'h0);

        // R4 unmask raises line, R9 capture
        wr_reg(2'd2, 32'h0000_0020);
        chk("R4 unmasked source raises line", {31'h0, irq}, 32'h1);
        capture();
        rd_reg(2'd3, "R9 captured vector 5", 32'h0000_2800);

        // R6 highest number wins
        pulse(32'h0000_0208);
        wr_reg(2'd2, 32'h0000_0228);
        capture();
        rd_reg(2'd3, "R6 highest source 9", 32'h0000_4800);

        // R7 promotion of source 3
        wr_reg(2'd0, 32'h0080_A3E4);
        capture();
        rd_reg(2'd3, "R7 promoted source 3", 32'h0000_1800);
        wr_reg(2'd0, 32'h0080_A0E4);

        // R3 write-one-clear, zeros ignored, set wins
        wr_reg(2'd1, 32'h0000_0200);
        rd_reg(2'd1, "R3 bit 9 cleared", 32'h0000_0028);
        wr_reg(2'd1, 32'h0);
        rd_reg(2'd1, "R3 zero write no effect", 32'h0000_0028);
        @(negedge clk);
        req = 31'h4; wr = 1'b1; addr = 2'd1; wdata = 32'h8;
        @(negedge clk);
        req = '0; wr = 1'b0; wdata = '0;
        rd_reg(2'd1, "R3 request beats clear", 32'h0000_0028);

        // R9 write without acknowledge bit keeps capture
        wr_reg(2'd3, 32'h0000_FFFE);
        rd_reg(2'd3, "R9 no capture without bit 0", 32'h0000_1800);

        // R11 mask race on presented source 5
        wr_reg(2'd2, 32'h0000_0208);
        rd_reg(2'd1, "R11 race flag set", 32'h0000_0029);
        capture();
        rd_reg(2'd3, "R11 next pick is 3", 32'h0000_1800);
        wr_reg(2'd1, 32'h0000_0028);
        chk("R11 race flag alone holds line", {31'h0, irq}, 32'h1);
        capture();
        rd_reg(2'd3, "R10 no source gives vector 0", 32'h0);
        wr_reg(2'd1, 32'h0000_0001);
        chk("R11 clearing flag drops line", {31'h0, irq}, 32'h0);

        // R8 fast slots: slot0=ch3, slot1=ch1, slot2=ch2, slot3=ch0
        wr_reg(2'd2, 32'hF800_0000);
        wr_reg(2'd0, 32'h0080_A027);
        pulse(32'h5000_0000);
        capture();
        rd_reg(2'd3, "R8 channel 0 in top slot", 32'h0000_E000);
        wr_reg(2'd1, 32'h5000_0000);
        pulse(32'h8800_0000);
        capture();
        rd_reg(2'd3, "R8 source 31 in slot 0 beats 27", 32'h0000_F800);
        wr_reg(2'd1, 32'h8800_0000);
        capture();
        rd_reg(2'd3, "R10 empty capture gives 0", 32'h0);

        // R8 channel 1 in no slot
        wr_reg(2'd0, 32'h0080_A02F);
        pulse(32'h2000_0000);
        chk("R5 unslotted channel still raises line", {31'h0, irq}, 32'h1);
        capture();
        rd_reg(2'd3, "R8 unslotted channel never picked", 32'h0);

        // R5 global enable off
        wr_reg(2'd0, 32'h0000_A02F);
        chk("R5 disabled line stays low", {31'h0, irq}, 32'h0);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule